// File: doc/BRIEF.md
# Prioritized Boot Source Selector

This block runs once after reset and decides where the processor fetches its first program. It first waits a programmable number of clock cycles, which stands in for the time the oscillator and clock multiplier need to settle. It then works through a fixed chain of checks and stops at the first one that succeeds. The checks, in order, are a debug strap, a two-byte signature read from an external parallel ROM, a removable-media strap with a wait for card presence, and the same signature read from a serial nonvolatile memory. If none of them succeeds, the block falls back to download from a host.

The two memory probes use a simple read port: the block raises a request with a byte address and holds it until an acknowledge returns with a data byte. If no acknowledge arrives within a bounded number of cycles, the probe counts as a failed signature and the chain moves on. The result is a one-hot source selection, a 16-bit start value and a one-cycle `decided` strobe. The selection and start value hold until the next reset. A power-down request stops the sequence at any point. Leaving power-down takes a fresh reset.

Top module: `boot_src_sel`

## Requirements
- R1: No memory request and no decision occurs until at least `settle_cycles` clock cycles have passed after `rst_n` rises. The count is taken from the input, so a larger value delays the decision further.
- R2: If `dbg_strap` is high when it is checked, the block selects the debug source (`boot_sel` = 5'b00001, `start_addr` = 0x0000) and issues no memory request.
- R3: The ROM probe reads byte address 0 and then byte address 1 on the ROM port. If it returns 0x44 ('D') and then 0x52 ('R'), the block selects the ROM source (`boot_sel` = 5'b00010, `start_addr` = 0x0400). The ROM is probed before either media or serial memory is considered.
- R4: If the ROM probe fails and `media_sel_n` is low, the block waits without deciding for as long as `media_present` stays low. Once `media_present` is high, it selects media (`boot_sel` = 5'b00100, `start_addr` = 0x0001, the reserved sector number).
- R5: If the ROM probe fails and `media_sel_n` is high, the serial memory is probed with the same two reads and the same signature. A match selects serial memory (`boot_sel` = 5'b01000, `start_addr` = 0x0000).
- R6: If every check fails, the block selects host download (`boot_sel` = 5'b10000, `start_addr` = 0x0000).
- R7: If a request gets no acknowledge within `TIMEOUT_CYC` cycles (default 16), the probe fails and the chain continues with the next check.
- R8: If the first byte returned is not 0x44, the probe fails at once and the second address is not read. A correct first byte followed by a wrong second byte also fails.
- R9: `decided` is high for exactly one cycle, and it is high together with a one-hot `boot_sel`. After that, `boot_sel` and `start_addr` hold their values until reset or power-down. `boot_sel` is never more than one-hot.
- R10: When `sleep_req` is high, the next cycle has `boot_sel` = 0 and no request active. Deasserting `sleep_req` does not restart the sequence. Only a new reset does.
- R11: The ROM and serial-memory requests are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sleep_req | input | 1 | Power-down request; halts the block until the next reset |
| settle_cycles | input | SETTLE_W | Number of settle cycles to wait after reset |
| dbg_strap | input | 1 | Debug strap; high selects the debugger |
| media_sel_n | input | 1 | Media strap; low selects the media path |
| media_present | input | 1 | Media presence detect |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_ack | input | 1 | ROM read acknowledge |
| rom_data | input | 8 | ROM read data, valid with `rom_ack` |
| nvm_req | output | 1 | Serial memory read request |
| nvm_addr | output | ADDR_W | Serial memory byte address |
| nvm_ack | input | 1 | Serial memory read acknowledge |
| nvm_data | input | 8 | Serial memory read data, valid with `nvm_ack` |
| boot_sel | output | 5 | One-hot selection: bit0 debug, bit1 ROM, bit2 media, bit3 serial memory, bit4 host |
| start_addr | output | 16 | Start address, or sector number for the media path |
| decided | output | 1 | One-cycle strobe when the decision is made |

## Verification
The assertions assume that each acknowledge is a single-cycle pulse that arrives only while its request is high. They also assume that `media_present` stays high at least until the cycle after the block samples it. The bench's responders meet the first assumption because they acknowledge once per request, half a cycle after they see it, and never answer a port whose memory is marked absent. They meet the second because they only ever raise `media_present` and hold it for the rest of the run.

// File: rtl/boot_src_pkg.sv
package boot_src_pkg;
  localparam int unsigned NUM_SRC = 5;

  // Bit index of each source in the one-hot selection; lower index wins.
  typedef enum logic [2:0] {
    SRC_DBG   = 3'd0,
    SRC_ROM   = 3'd1,
    SRC_MEDIA = 3'd2,
    SRC_NVM   = 3'd3,
    SRC_HOST  = 3'd4
  } boot_src_e;

  localparam logic [7:0] SIG_BYTE0 = 8'h44;
  localparam logic [7:0] SIG_BYTE1 = 8'h52;

  typedef enum logic [2:0] {
    SQ_SETTLE,
    SQ_DBG,
    SQ_ROM,
    SQ_MEDIA_CHK,
    SQ_MEDIA_WAIT,
    SQ_NVM,
    SQ_DONE,
    SQ_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    PR_IDLE,
    PR_REQ,
    PR_GAP,
    PR_DONE
  } probe_state_e;
endpackage

// File: rtl/boot_settle_timer.sv
module boot_settle_timer #(
  parameter int unsigned SETTLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic [SETTLE_W-1:0] limit,
  output logic                done
);
  logic [SETTLE_W-1:0] cnt_q, cnt_d;

  assign done = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && !done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/boot_sig_probe.sv
module boot_sig_probe
  import boot_src_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  input  logic              ack,
  input  logic [7:0]        data,
  output logic              done,
  output logic              match
);
  localparam int unsigned TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);

  probe_state_e    st_q, st_d;
  logic            idx_q, idx_d;
  logic            hit_q, hit_d;
  logic [TO_W-1:0] tmo_q, tmo_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    hit_d = hit_q;
    tmo_d = tmo_q;
    unique case (st_q)
      PR_IDLE: begin
        if (start) begin
          st_d  = PR_REQ;
          idx_d = 1'b0;
          hit_d = 1'b0;
          tmo_d = '0;
        end
      end
      PR_REQ: begin
        if (ack) begin
          tmo_d = '0;
          if (!idx_q) begin
            if (data == SIG_BYTE0) begin
              idx_d = 1'b1;
              st_d  = PR_GAP;
            end else begin
              hit_d = 1'b0;
              st_d  = PR_DONE;
            end
          end else begin
            hit_d = (data == SIG_BYTE1);
            st_d  = PR_DONE;
          end
        end else if (tmo_q == TO_LAST) begin
          hit_d = 1'b0;
          st_d  = PR_DONE;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      PR_GAP:  st_d = PR_REQ;
      PR_DONE: st_d = PR_IDLE;
      default: st_d = PR_IDLE;
    endcase
    if (abort) st_d = PR_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PR_IDLE;
      idx_q <= 1'b0;
      hit_q <= 1'b0;
      tmo_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      hit_q <= hit_d;
      tmo_q <= tmo_d;
    end
  end

  assign req   = (st_q == PR_REQ);
  assign addr  = {{(ADDR_W-1){1'b0}}, idx_q};
  assign done  = (st_q == PR_DONE);
  assign match = done && hit_q;
endmodule

// File: rtl/boot_src_sel.sv
module boot_src_sel
  import boot_src_pkg::*;
#(
  parameter int unsigned SETTLE_W     = 24,
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned TIMEOUT_CYC  = 16,
  parameter logic [15:0] DBG_START    = 16'h0000,
  parameter logic [15:0] ROM_START    = 16'h0400,
  parameter logic [15:0] MEDIA_SECTOR = 16'h0001,
  parameter logic [15:0] NVM_START    = 16'h0000,
  parameter logic [15:0] HOST_START   = 16'h0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                dbg_strap,
  input  logic                media_sel_n,
  input  logic                media_present,
  output logic                rom_req,
  output logic [ADDR_W-1:0]   rom_addr,
  input  logic                rom_ack,
  input  logic [7:0]          rom_data,
  output logic                nvm_req,
  output logic [ADDR_W-1:0]   nvm_addr,
  input  logic                nvm_ack,
  input  logic [7:0]          nvm_data,
  output logic [4:0]          boot_sel,
  output logic [15:0]         start_addr,
  output logic                decided
);
  // Reset: asserts asynchronously, releases on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_state_e         st_q, st_d;
  logic [NUM_SRC-1:0] sel_q, sel_d;
  logic [15:0]        addr_q, addr_d;
  logic               dec_q, dec_d;
  logic               settle_done, settle_clr, settle_en;
  logic               rom_go, nvm_go;
  logic               rom_done, rom_match, nvm_done, nvm_match;
  logic               pick;
  boot_src_e          pick_src;

  function automatic logic [15:0] src_start(input boot_src_e s);
    logic [15:0] v;
    unique case (s)
      SRC_DBG:   v = DBG_START;
      SRC_ROM:   v = ROM_START;
      SRC_MEDIA: v = MEDIA_SECTOR;
      SRC_NVM:   v = NVM_START;
      default:   v = HOST_START;
    endcase
    return v;
  endfunction

  assign settle_clr = sleep_req || (st_q == SQ_HALT);
  assign settle_en  = (st_q == SQ_SETTLE);

  boot_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (settle_clr),
    .en    (settle_en),
    .limit (settle_cycles),
    .done  (settle_done)
  );

  boot_sig_probe #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_rom_probe (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (rom_go),
    .abort (sleep_req),
    .req   (rom_req),
    .addr  (rom_addr),
    .ack   (rom_ack),
    .data  (rom_data),
    .done  (rom_done),
    .match (rom_match)
  );

  boot_sig_probe #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_nvm_probe (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (nvm_go),
    .abort (sleep_req),
    .req   (nvm_req),
    .addr  (nvm_addr),
    .ack   (nvm_ack),
    .data  (nvm_data),
    .done  (nvm_done),
    .match (nvm_match)
  );

  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    addr_d   = addr_q;
    dec_d    = 1'b0;
    rom_go   = 1'b0;
    nvm_go   = 1'b0;
    pick     = 1'b0;
    pick_src = SRC_HOST;
    unique case (st_q)
      SQ_SETTLE: if (settle_done) st_d = SQ_DBG;
      SQ_DBG: begin
        if (dbg_strap) begin
          pick     = 1'b1;
          pick_src = SRC_DBG;
        end else begin
          rom_go = 1'b1;
          st_d   = SQ_ROM;
        end
      end
      SQ_ROM: begin
        if (rom_done) begin
          if (rom_match) begin
            pick     = 1'b1;
            pick_src = SRC_ROM;
          end else begin
            st_d = SQ_MEDIA_CHK;
          end
        end
      end
      SQ_MEDIA_CHK: begin
        if (!media_sel_n) begin
          st_d = SQ_MEDIA_WAIT;
        end else begin
          nvm_go = 1'b1;
          st_d   = SQ_NVM;
        end
      end
      SQ_MEDIA_WAIT: begin
        if (media_present) begin
          pick     = 1'b1;
          pick_src = SRC_MEDIA;
        end
      end
      SQ_NVM: begin
        if (nvm_done) begin
          pick     = 1'b1;
          pick_src = nvm_match ? SRC_NVM : SRC_HOST;
        end
      end
      default: st_d = st_q;
    endcase
    if (pick) begin
      st_d   = SQ_DONE;
      sel_d  = NUM_SRC'(1) << pick_src;
      addr_d = src_start(pick_src);
      dec_d  = 1'b1;
    end
    if (sleep_req) begin
      st_d   = SQ_HALT;
      sel_d  = '0;
      addr_d = '0;
      dec_d  = 1'b0;
      rom_go = 1'b0;
      nvm_go = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q   <= SQ_SETTLE;
      sel_q  <= '0;
      addr_q <= '0;
      dec_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      addr_q <= addr_d;
      dec_q  <= dec_d;
    end
  end

  assign boot_sel   = sel_q;
  assign start_addr = addr_q;
  assign decided    = dec_q;
endmodule

// File: rtl/boot_src_sel_chk.sv
module boot_src_sel_chk #(
  parameter logic [15:0] ROM_START = 16'h0400
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_req,
  input logic        media_present,
  input logic        rom_req,
  input logic        nvm_req,
  input logic [4:0]  boot_sel,
  input logic [15:0] start_addr,
  input logic        decided
);
  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(boot_sel));

  p_decided_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decided |=> !decided);

  p_decided_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decided |-> ($countones(boot_sel) == 1));

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|boot_sel) && !sleep_req) |=> (boot_sel == $past(boot_sel)));

  p_rom_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && boot_sel[1]) |-> (start_addr == ROM_START));

  p_media_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && boot_sel[2]) |-> $past(media_present));

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (boot_sel == 5'b0 && !rom_req && !nvm_req && !decided));

  p_ports_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_req && nvm_req));
endmodule

bind boot_src_sel boot_src_sel_chk #(.ROM_START(ROM_START)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_req     (sleep_req),
  .media_present (media_present),
  .rom_req       (rom_req),
  .nvm_req       (nvm_req),
  .boot_sel      (boot_sel),
  .start_addr    (start_addr),
  .decided       (decided)
);

// File: tb/boot_src_sel_test.sv
module boot_src_sel_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SW = 24;
  localparam int  AW = 16;

  logic          clk;
  logic          rst_n;
  logic          sleep_req;
  logic [SW-1:0] settle_cycles;
  logic          dbg_strap, media_sel_n, media_present;
  logic          rom_req, rom_ack, nvm_req, nvm_ack;
  logic [AW-1:0] rom_addr, nvm_addr;
  logic [7:0]    rom_data, nvm_data;
  logic [4:0]    boot_sel;
  logic [15:0]   start_addr;
  logic          decided;

  boot_src_sel uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .settle_cycles(settle_cycles),
    .dbg_strap(dbg_strap), .media_sel_n(media_sel_n), .media_present(media_present),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack), .rom_data(rom_data),
    .nvm_req(nvm_req), .nvm_addr(nvm_addr), .nvm_ack(nvm_ack), .nvm_data(nvm_data),
    .boot_sel(boot_sel), .start_addr(start_addr), .decided(decided)
  );

  int checks = 0;
  int fails  = 0;
  int dec_cnt = 0;
  int rom_reads = 0;
  int nvm_reads = 0;
  int rom_bad_order = 0;
  logic rom_en, nvm_en;
  logic [7:0] rom_b0, rom_b1, nvm_b0, nvm_b1;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory responders: one ack per request, driven on the falling edge.
  always @(negedge clk) begin
    rom_ack = 1'b0;
    if (rom_req && rom_en && rom_ack == 1'b0 && !$isunknown(rom_addr)) begin
      if (rom_addr != AW'(rom_reads)) rom_bad_order++;
      rom_data = (rom_addr == '0) ? rom_b0 : rom_b1;
      rom_ack  = 1'b1;
      rom_reads++;
    end
    nvm_ack = 1'b0;
    if (nvm_req && nvm_en) begin
      nvm_data = (nvm_addr == '0) ? nvm_b0 : nvm_b1;
      nvm_ack  = 1'b1;
      nvm_reads++;
    end
    if (decided) dec_cnt++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dbg, input logic msn, input logic pres,
                          input logic ren, input logic [7:0] r0, input logic [7:0] r1,
                          input logic nen, input logic [7:0] n0, input logic [7:0] n1,
                          input int settle);
    @(negedge clk);
    rst_n = 1'b0;
    sleep_req = 1'b0;
    settle_cycles = SW'(settle);
    dbg_strap = dbg; media_sel_n = msn; media_present = pres;
    rom_en = ren; rom_b0 = r0; rom_b1 = r1;
    nvm_en = nen; nvm_b0 = n0; nvm_b1 = n1;
    repeat (3) @(negedge clk);
    dec_cnt = 0; rom_reads = 0; nvm_reads = 0; rom_bad_order = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_dec(input int cap, output int cyc);
    cyc = 0;
    while (dec_cnt == 0 && cyc < cap) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  typedef struct packed {
    logic       dbg;
    logic       msn;
    logic       pres;
    logic       ren;
    logic [7:0] r0;
    logic [7:0] r1;
    logic       nen;
    logic [7:0] n0;
    logic [7:0] n1;
    logic [4:0] sel;
    logic [15:0] addr;
    logic [3:0] rreads;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    // R2: debug strap wins, no reads
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'h44, 8'h52, 1'b1, 8'h44, 8'h52, 5'b00001, 16'h0000, 4'd0},
    // R3: ROM signature
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'h44, 8'h52, 1'b1, 8'h44, 8'h52, 5'b00010, 16'h0400, 4'd2},
    // R4, R8: wrong second byte, media selected, present
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h44, 8'h58, 1'b1, 8'h44, 8'h52, 5'b00100, 16'h0001, 4'd2},
    // R5, R8: wrong first byte -> one read, serial memory matches
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'h41, 8'h52, 1'b1, 8'h44, 8'h52, 5'b01000, 16'h0000, 4'd1},
    // R7: ROM silent -> timeout, serial memory matches
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h44, 8'h52, 1'b1, 8'h44, 8'h52, 5'b01000, 16'h0000, 4'd0},
    // R6, R7: everything fails, serial memory silent
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h44, 8'h52, 5'b10000, 16'h0000, 4'd0},
    // R6: serial memory wrong signature
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'h52, 8'h44, 1'b1, 8'h44, 8'h44, 5'b10000, 16'h0000, 4'd1},
    // R3: ROM has priority over media and serial memory
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h44, 8'h52, 1'b1, 8'h44, 8'h52, 5'b00010, 16'h0400, 4'd2}
  };

  initial begin
    int cyc;
    int wd_fired = 0;
    rst_n = 1'b0; sleep_req = 1'b0; settle_cycles = '0;
    dbg_strap = 1'b0; media_sel_n = 1'b1; media_present = 1'b0;
    rom_en = 1'b0; nvm_en = 1'b0; rom_ack = 1'b0; nvm_ack = 1'b0;
    rom_data = '0; nvm_data = '0;
    rom_b0 = '0; rom_b1 = '0; nvm_b0 = '0; nvm_b1 = '0;

    fork
      begin : watchdog
        repeat (150000) @(posedge clk);
        wd_fired = 1;
      end
      begin : body
        // Reset state (R9)
        repeat (3) @(negedge clk);
        check(boot_sel == 5'b0 && !decided && !rom_req && !nvm_req, "R9 reset state",
              {boot_sel, decided, rom_req, nvm_req}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
          do_reset(TBL[i].dbg, TBL[i].msn, TBL[i].pres, TBL[i].ren, TBL[i].r0, TBL[i].r1,
                   TBL[i].nen, TBL[i].n0, TBL[i].n1, 8);
          wait_dec(400, cyc);
          @(negedge clk);
          check(boot_sel == TBL[i].sel, $sformatf("R2-R8 row %0d boot_sel", i), boot_sel, TBL[i].sel);
          check(start_addr == TBL[i].addr, $sformatf("table row %0d start_addr", i), start_addr, TBL[i].addr);
          check(rom_reads == int'(TBL[i].rreads) && rom_bad_order == 0,
                $sformatf("R3 R8 row %0d rom reads", i), rom_reads, TBL[i].rreads);
        end

        // R1: settle delay, small and large
        do_reset(1'b1, 1'b1, 1'b0, 1'b1, 8'h44, 8'h52, 1'b1, 8'h44, 8'h52, 40);
        wait_dec(1000, cyc);
        check(cyc >= 40 && cyc <= 48, "R1 settle 40", cyc, 40);
        do_reset(1'b1, 1'b1, 1'b0, 1'b1, 8'h44, 8'h52, 1'b1, 8'h44, 8'h52, 200);
        wait_dec(1000, cyc);
        check(cyc >= 200 && cyc <= 208, "R1 settle 200", cyc, 200);
        check(rom_reads == 0 && nvm_reads == 0, "R2 no reads on debug path", rom_reads + nvm_reads, 0);

        // R4: wait for media presence, then R9 pulse and hold
        do_reset(1'b0, 1'b0, 1'b0, 1'b1, 8'h41, 8'h00, 1'b1, 8'h44, 8'h52, 5);
        repeat (300) @(negedge clk);
        check(dec_cnt == 0 && boot_sel == 5'b0, "R4 no decision while media absent", dec_cnt, 0);
        check(nvm_reads == 0, "R4 serial memory not probed on media path", nvm_reads, 0);
        media_present = 1'b1;
        wait_dec(20, cyc);
        @(negedge clk);
        check(boot_sel == 5'b00100 && start_addr == 16'h0001, "R4 media selected",
              {boot_sel, start_addr}, {5'b00100, 16'h0001});
        repeat (50) @(negedge clk);
        check(dec_cnt == 1, "R9 decided single pulse", dec_cnt, 1);
        check(boot_sel == 5'b00100 && start_addr == 16'h0001, "R9 outputs hold",
              {boot_sel, start_addr}, {5'b00100, 16'h0001});

        // R10: power-down during media wait, release does not resume
        do_reset(1'b0, 1'b0, 1'b0, 1'b1, 8'h41, 8'h00, 1'b1, 8'h44, 8'h52, 5);
        repeat (60) @(negedge clk);
        sleep_req = 1'b1;
        repeat (2) @(negedge clk);
        check(boot_sel == 5'b0 && !rom_req && !nvm_req, "R10 quiet in power-down",
              {boot_sel, rom_req, nvm_req}, 0);
        sleep_req = 1'b0;
        media_present = 1'b1;
        repeat (200) @(negedge clk);
        check(dec_cnt == 0 && boot_sel == 5'b0, "R10 no restart without reset", dec_cnt, 0);
        do_reset(1'b0, 1'b0, 1'b1, 1'b1, 8'h41, 8'h00, 1'b1, 8'h44, 8'h52, 5);
        wait_dec(400, cyc);
        @(negedge clk);
        check(boot_sel == 5'b00100, "R10 reset restarts sequence", boot_sel, 5'b00100);

        // R10: power-down after a decision clears selection
        do_reset(1'b0, 1'b1, 1'b0, 1'b1, 8'h44, 8'h52, 1'b1, 8'h44, 8'h52, 5);
        wait_dec(400, cyc);
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        check(boot_sel == 5'b0 && start_addr == 16'h0, "R10 decision cleared",
              {boot_sel, start_addr}, 0);
        sleep_req = 1'b0;

        // R7: ROM silent for the whole timeout, exactly one request window, no reads
        do_reset(1'b0, 1'b1, 1'b0, 1'b0, 8'h44, 8'h52, 1'b0, 8'h44, 8'h52, 5);
        wait_dec(400, cyc);
        check(cyc >= 32 && dec_cnt == 1, "R7 both timeouts elapse", cyc, 32);
        @(negedge clk);
        check(boot_sel == 5'b10000, "R7 host fallback after timeouts", boot_sel, 5'b10000);
      end
    join_any
    disable fork;
    if (wd_fired != 0) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule